// File: doc/BRIEF.md
# Byte-Masked Write Memory

This block is the write-control path of a word-wide synchronous memory that is split into byte lanes. Each clock edge it turns three active-low controls into a per-lane write mask. The controls are a global write, a byte-write enable and one strobe per lane. On that same edge it writes the selected lanes of the addressed word in a small internal array. A write needs no handshake. It starts and completes on the edge that samples it.

A global write stores the whole word and ignores the byte controls. A byte write needs the enable and the lane strobes together. A snooze input stops all activity while it is high. During snooze nothing is written, the read output rests at zero, and the array keeps every bit it holds. A registered read port returns the addressed word one edge after a read request. Reads see the contents from before any write made on the same edge.

Top module: `bytemask_wr_mem`

## Requirements
- R1: After reset, `rdata_o` is zero and every word of the array reads back as zero.
- R2: With snooze low and `gw_n_i` low, every lane of the addressed word is written from `wdata_i`, whatever the values of `bwe_n_i` and `bw_n_i`.
- R3: With snooze low, `gw_n_i` high and `bwe_n_i` low, lane i (data bits [8i+7:8i]) is written exactly when `bw_n_i[i]` is low. Any number of lanes from none to all may be written.
- R4: With `gw_n_i` and `bwe_n_i` both high, no lane is written, whatever the value of `bw_n_i`.
- R5: Lanes that are not selected for a write keep their previous contents bit for bit.
- R6: A read request with snooze low loads `rdata_o` on the next edge with the word stored before that edge. A write made on the same edge becomes visible to the following read.
- R7: While `snooze_i` is high, no write takes place, and `rdata_o` is zero from the first edge that samples snooze high.
- R8: The array contents survive snooze unchanged. Reads and writes act normally from the first edge after snooze falls.
- R9: With snooze low and `rd_en_i` low, `rdata_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze_i | input | 1 | High: power-down, all accesses suspended |
| gw_n_i | input | 1 | Active-low global write, all lanes |
| bwe_n_i | input | 1 | Active-low enable qualifying the byte strobes |
| bw_n_i | input | 4 | Active-low per-lane byte strobes |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 32 | Registered read data |

## Verification
A wrong mask decode leaves the array wrong, and the array can only be seen through the read port. The fault therefore appears one edge after the next read of the damaged word. That read shows which lanes were changed or missed, compared against a reference array. A snooze fault appears sooner. If `rdata_o` is non-zero one edge after snooze rises, the gating is broken. A write that leaks during snooze shows up on the first read after snooze falls.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Kind of write selected by the active-low controls in one cycle
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_BYTES  = 2'd1,
        WR_GLOBAL = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/bwm_mask_decode.sv
module bwm_mask_decode
    import bwm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             snooze_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    output logic [LANES-1:0] wr_mask_o
);

    wr_kind_e kind;

    // Global write takes priority over the byte controls; snooze blocks both
    always_comb begin
        if (snooze_i)      kind = WR_NONE;
        else if (!gw_n_i)  kind = WR_GLOBAL;
        else if (!bwe_n_i) kind = WR_BYTES;
        else               kind = WR_NONE;
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign wr_mask_o[ln] = (kind == WR_GLOBAL) ||
                               ((kind == WR_BYTES) && !bw_n_i[ln]);
    end

endmodule

// File: rtl/bwm_lane_store.sv
module bwm_lane_store #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snooze_i,
    input  logic [LANES-1:0]        wr_mask_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    rd_en_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Read path samples the pre-write word; snooze parks it at zero
        if (snooze_i) begin
            st_d.rdata = '0;
        end else if (rd_en_i) begin
            st_d.rdata = st_q.mem[addr_i];
        end
        for (int ln = 0; ln < LANES; ln++) begin
            if (wr_mask_i[ln]) begin
                st_d.mem[addr_i][ln*LANE_W +: LANE_W] = wdata_i[ln*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/bytemask_wr_mem.sv
module bytemask_wr_mem #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 16,
    localparam int LANES  = DATA_W / LANE_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snooze_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [LANES-1:0] wr_mask;

    bwm_mask_decode #(
        .LANES (LANES)
    ) u_decode (
        .snooze_i  (snooze_i),
        .gw_n_i    (gw_n_i),
        .bwe_n_i   (bwe_n_i),
        .bw_n_i    (bw_n_i),
        .wr_mask_o (wr_mask)
    );

    bwm_lane_store #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .snooze_i  (snooze_i),
        .wr_mask_i (wr_mask),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rd_en_i   (rd_en_i),
        .rdata_o   (rdata_o)
    );

endmodule

// File: rtl/bytemask_wr_mem_chk.sv
module bytemask_wr_mem_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snooze_i,
    input logic              gw_n_i,
    input logic              bwe_n_i,
    input logic [LANES-1:0]  bw_n_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [LANES-1:0]  wr_mask
);

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze_i && !gw_n_i) |-> (wr_mask == {LANES{1'b1}}));  // R2

    AST_BYTE_STROBE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && !bwe_n_i) |-> ((wr_mask & bw_n_i) == '0));  // R3

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n_i && bwe_n_i) |-> (wr_mask == '0));  // R4

    AST_SNOOZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        snooze_i |-> (wr_mask == '0));  // R7

    AST_SNOOZE_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        snooze_i |=> (rdata_o == '0));  // R7

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze_i && !rd_en_i) |=> $stable(rdata_o));  // R9

endmodule

bind bytemask_wr_mem bytemask_wr_mem_chk #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .snooze_i (snooze_i),
    .gw_n_i   (gw_n_i),
    .bwe_n_i  (bwe_n_i),
    .bw_n_i   (bw_n_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .wr_mask  (wr_mask)
);

// File: tb/bytemask_wr_mem_tb.sv
`timescale 1ns/1ps
module bytemask_wr_mem_tb;

    typedef struct packed {
        logic        snz;
        logic        gw_n;
        logic        bwe_n;
        logic [3:0]  bw_n;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic        rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        vec_t'{1'b0, 1'b0, 1'b1, 4'hF, 4'd1, 32'hA1A2A3A4, 1'b0, 4'd2}, // R2 global, strobes idle
        vec_t'{1'b0, 1'b1, 1'b1, 4'h0, 4'd1, 32'hFFFFFFFF, 1'b1, 4'd4}, // R4 strobes low, no enable
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0, 1'b1, 4'd4},        // R4 read back unchanged
        vec_t'{1'b0, 1'b1, 1'b0, 4'hE, 4'd1, 32'h11223344, 1'b0, 4'd3}, // R3 lane 0 only
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0, 1'b1, 4'd5},        // R5 other lanes kept
        vec_t'{1'b0, 1'b1, 1'b0, 4'h5, 4'd1, 32'h55667788, 1'b0, 4'd3}, // R3 lanes 1 and 3
        vec_t'{1'b0, 1'b1, 1'b0, 4'hF, 4'd1, 32'h99999999, 1'b1, 4'd3}, // R3 enable, no strobe
        vec_t'{1'b0, 1'b0, 1'b1, 4'hF, 4'd1, 32'hDEADBEEF, 1'b1, 4'd6}, // R6 read during write
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0, 1'b1, 4'd6},        // R6 new word visible
        vec_t'{1'b1, 1'b0, 1'b0, 4'h0, 4'd2, 32'hCAFEF00D, 1'b1, 4'd7}, // R7 write blocked, out idle
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd2, 32'h0, 1'b1, 4'd8},        // R8 nothing landed
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd7, 32'h0, 1'b0, 4'd9},        // R9 hold
        vec_t'{1'b0, 1'b0, 1'b0, 4'hF, 4'd3, 32'h01020304, 1'b0, 4'd2}, // R2 global beats idle strobes
        vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0, 1'b1, 4'd2}         // R2 read back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snooze_i = 1'b0;
    logic        gw_n_i = 1'b1;
    logic        bwe_n_i = 1'b1;
    logic [3:0]  bw_n_i = 4'hF;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rdata_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] ref_mem [16];
    logic [31:0] ref_rdata;

    always #4 clk = ~clk;

    bytemask_wr_mem u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .snooze_i (snooze_i),
        .gw_n_i   (gw_n_i),
        .bwe_n_i  (bwe_n_i),
        .bw_n_i   (bw_n_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rd_en_i  (rd_en_i),
        .rdata_o  (rdata_o)
    );

    function automatic logic [3:0] ref_mask(vec_t v);
        if (v.snz)        return 4'h0;
        else if (!v.gw_n) return 4'hF;
        else if (!v.bwe_n) return ~v.bw_n;
        else              return 4'h0;
    endfunction

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: rdata_o actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge act, compare at the next falling edge
    task automatic apply(input vec_t v);
        logic [3:0] m;
        snooze_i = v.snz;
        gw_n_i   = v.gw_n;
        bwe_n_i  = v.bwe_n;
        bw_n_i   = v.bw_n;
        addr_i   = v.addr;
        wdata_i  = v.wdata;
        rd_en_i  = v.rd;
        @(posedge clk);
        @(negedge clk);
        if (v.snz)     ref_rdata = '0;
        else if (v.rd) ref_rdata = ref_mem[v.addr];
        m = ref_mask(v);
        for (int ln = 0; ln < 4; ln++) begin
            if (m[ln]) ref_mem[v.addr][ln*8 +: 8] = v.wdata[ln*8 +: 8];
        end
        check(int'(v.req), rdata_o, ref_rdata);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = '0;
        ref_rdata = '0;
        repeat (3) @(negedge clk);
        check(1, rdata_o, 32'h0); // R1 output idle in reset
        rst_n = 1'b1;
        @(negedge clk);

        // R1: array cleared by reset
        for (int a = 0; a < 16; a += 5) begin
            apply(vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'(a), 32'h0, 1'b1, 4'd1});
        end

        for (int i = 0; i < NVEC; i++) apply(VECS[i]);

        // R8: contents retained over several snooze cycles with writes attempted
        apply(vec_t'{1'b0, 1'b0, 1'b1, 4'hF, 4'd5, 32'h5A5AA5A5, 1'b0, 4'd8});
        for (int k = 0; k < 4; k++) begin
            apply(vec_t'{1'b1, 1'b0, 1'b0, 4'h0, 4'd5, 32'h0BAD0BAD, 1'b1, 4'd7}); // R7
        end
        apply(vec_t'{1'b0, 1'b1, 1'b0, 4'hC, 4'd5, 32'h77778888, 1'b1, 4'd8}); // R8 first edge after
        apply(vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0, 1'b1, 4'd8});
        // R3: all four strobes at once
        apply(vec_t'{1'b0, 1'b1, 1'b0, 4'h0, 4'd9, 32'h13579BDF, 1'b0, 4'd3});
        apply(vec_t'{1'b0, 1'b1, 1'b1, 4'hF, 4'd9, 32'h0, 1'b1, 4'd3});
        // R9: idle read with write in flight keeps output
        apply(vec_t'{1'b0, 1'b0, 1'b1, 4'hF, 4'd9, 32'h24682468, 1'b0, 4'd9});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule